// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one translation entry from a flat table in physical memory. A requester presents a 40-bit virtual address together with an access kind: load, store or instruction fetch. The upper 26 bits are the virtual page number, and they index the table directly. The lower 14 bits are the offset within a 16 KiB page, and they pass through unchanged. A base register holds the physical location of the table. Only a write made in kernel mode updates it.

For each request the walker issues a single memory read for the 32-bit entry. It waits as long as the memory takes to answer, then checks the entry. If the entry is valid and its rights allow the requested access, the response carries a 36-bit physical address. Otherwise it carries a fault code and a zero address. Only one walk is in flight at a time, and a busy flag tells the requester when a new request is accepted.

The controller is a four-state machine. IDLE accepts a request and goes to READ_PTE. READ_PTE issues the memory read for one cycle and always goes to WAIT_PTE. WAIT_PTE holds until read data arrives and then goes to RESPOND. RESPOND presents the result for one cycle and always returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: On a successful translation, rsp_paddr equals {entry bits 21:0, virtual address bits 13:0}. The page offset is carried through unchanged.
- R2: Each accepted request produces exactly one single-cycle mem_req. mem_addr equals the base register plus the virtual page number (virtual address bits 39:14) multiplied by 4, truncated to 36 bits. mem_req is high in the cycle right after acceptance.
- R3: Entry layout: bit 31 is the valid flag, bits 25:24 are the rights code and bits 21:0 are the physical page number. An entry with bit 31 = 0 gives rsp_status = 01 (page fault) and rsp_paddr = 0.
- R4: The rights code is 00 for none, 01 for read-only, 10 for read/write and 11 for execute-only. The access kind is 00 for load, 01 for store, 10 for fetch and 11 reserved. A load needs rights 01 or 10, a store needs 10 and a fetch needs 11; a reserved kind is never allowed. A valid entry that disallows the access gives rsp_status = 10 (protection fault) and rsp_paddr = 0. An allowed access gives rsp_status = 00.
- R5: A page fault takes precedence over a protection fault: an invalid entry reports 01 whatever its rights bits hold.
- R6: A base-register write (base_wr_en) takes effect only when kern_mode = 1. A write with kern_mode = 0 leaves the table location unchanged.
- R7: A kernel write that arrives while a walk is in progress does not affect that walk's read address. It is applied when that walk completes, so the next walk uses it.
- R8: busy is high from the cycle after acceptance through the RESPOND cycle. A req_valid that arrives while busy is high is ignored and causes no memory read.
- R9: The sequence is IDLE → READ_PTE → WAIT_PTE → RESPOND → IDLE. rsp_valid is a one-cycle pulse in the cycle after mem_rsp_valid is seen, so it comes 2 + L cycles after acceptance when memory answers L cycles after mem_req. mem_req and rsp_valid are never high together.
- R10: After reset the walker is idle: busy, mem_req and rsp_valid are 0, and the base register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kern_mode | input | 1 | Requester is in kernel mode |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | 36 | New table base address |
| req_valid | input | 1 | Translation request strobe, taken when busy is 0 |
| req_vaddr | input | 40 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory read request for one cycle |
| mem_addr | output | 36 | Physical address of the table entry |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | Result pulse |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| rsp_paddr | output | 36 | Physical address, zero on a fault |

## Verification
Translations are tried against entries of every rights code, crossed with all three access kinds and the reserved kind. This separates the allow/deny decision for each pairing and shows that a fault zeroes the address. An invalid entry whose rights bits would allow the access shows that the page fault wins over the protection fault. Page numbers at zero and at the all-ones maximum, and offsets at the all-ones value, expose errors in the index scaling and in the offset concatenation. Base writes in user mode, in kernel mode while idle and in kernel mode mid-walk are each followed by a walk whose read address shows which base was used, and varying memory latency checks the response timing.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ_PTE = 2'd1,
        ST_WAIT_PTE = 2'd2,
        ST_RESPOND  = 2'd3
    } walk_state_e;

    localparam logic [1:0] KIND_LOAD  = 2'b00;
    localparam logic [1:0] KIND_STORE = 2'b01;
    localparam logic [1:0] KIND_FETCH = 2'b10;

    localparam logic [1:0] RIGHT_NONE = 2'b00;
    localparam logic [1:0] RIGHT_RO   = 2'b01;
    localparam logic [1:0] RIGHT_RW   = 2'b10;
    localparam logic [1:0] RIGHT_EXEC = 2'b11;

    localparam logic [1:0] STAT_OK     = 2'b00;
    localparam logic [1:0] STAT_PFAULT = 2'b01;
    localparam logic [1:0] STAT_PROT   = 2'b10;

    localparam int RIGHTS_LSB = 24;

endpackage

// File: rtl/pw_pte_check.sv
module pw_pte_check
    import pw_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PPN_W = 22
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       kind,
    output logic [1:0]       status,
    output logic [PPN_W-1:0] ppn
);

    logic       present;
    logic [1:0] rights;
    logic       allowed;
    logic       unused_pte_bits;

    assign present = pte[PTE_W-1];
    assign rights  = pte[RIGHTS_LSB +: 2];
    assign ppn     = pte[PPN_W-1:0];
    assign unused_pte_bits = ^{pte[PTE_W-2:RIGHTS_LSB+2], pte[RIGHTS_LSB-1:PPN_W]};

    always_comb begin
        allowed = 1'b0;
        unique case (kind)
            KIND_LOAD:  allowed = (rights == RIGHT_RO) || (rights == RIGHT_RW);
            KIND_STORE: allowed = (rights == RIGHT_RW);
            KIND_FETCH: allowed = (rights == RIGHT_EXEC);
            default:    allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!present) begin
            status = STAT_PFAULT;
        end else if (!allowed) begin
            status = STAT_PROT;
        end else begin
            status = STAT_OK;
        end
    end

endmodule

// File: rtl/pw_base_reg.sv
module pw_base_reg #(
    parameter int PA_W = 36
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kern_mode,
    input  logic            wr_en,
    input  logic [PA_W-1:0] wr_data,
    input  logic            walk_busy,
    input  logic            walk_done,
    output logic [PA_W-1:0] base_q
);

    logic            wr_ok;
    logic            pend_q;
    logic [PA_W-1:0] pend_data_q;

    assign wr_ok = wr_en && kern_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            pend_q      <= 1'b0;
            pend_data_q <= '0;
        end else if (walk_done) begin
            if (wr_ok) begin
                base_q <= wr_data;
            end else if (pend_q) begin
                base_q <= pend_data_q;
            end
            pend_q <= 1'b0;
        end else if (wr_ok && walk_busy) begin
            pend_q      <= 1'b1;
            pend_data_q <= wr_data;
        end else if (wr_ok) begin
            base_q <= wr_data;
        end
    end

    // R6: without a kernel write and with nothing pending, the base stays put
    a_r6_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !pend_q) |=> $stable(base_q));

    // R7: the base never moves during a walk before it completes
    a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && !walk_done) |=> $stable(base_q));

endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm
    import pw_pkg::*;
#(
    parameter int VA_W  = 40,
    parameter int PA_W  = 36,
    parameter int OFS_W = 14,
    parameter int PTE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_kind,
    input  logic [PA_W-1:0]    base,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_data,
    input  logic [1:0]         chk_status,
    input  logic [PA_W-OFS_W-1:0] chk_ppn,
    output logic [PTE_W-1:0]   pte_q,
    output logic [1:0]         kind_q,
    output logic               busy,
    output logic               walk_done,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    output logic               rsp_valid,
    output logic [1:0]         rsp_status,
    output logic [PA_W-1:0]    rsp_paddr
);

    localparam int VPN_W = VA_W - OFS_W;

    walk_state_e      state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic [OFS_W-1:0] ofs_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_READ_PTE;
            ST_READ_PTE: state_d = ST_WAIT_PTE;
            ST_WAIT_PTE: if (mem_rsp_valid) state_d = ST_RESPOND;
            ST_RESPOND:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
            ofs_q   <= '0;
            kind_q  <= KIND_LOAD;
            pte_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                vpn_q  <= req_vaddr[VA_W-1:OFS_W];
                ofs_q  <= req_vaddr[OFS_W-1:0];
                kind_q <= req_kind;
            end
            if (state_q == ST_WAIT_PTE && mem_rsp_valid) begin
                pte_q <= mem_rsp_data;
            end
        end
    end

    always_comb begin
        busy       = 1'b1;
        walk_done  = 1'b0;
        mem_req    = 1'b0;
        mem_addr   = '0;
        rsp_valid  = 1'b0;
        rsp_status = STAT_OK;
        rsp_paddr  = '0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_READ_PTE: begin
                mem_req  = 1'b1;
                mem_addr = base + PA_W'({vpn_q, 2'b00});
            end
            ST_WAIT_PTE: begin
                busy = 1'b1;
            end
            ST_RESPOND: begin
                walk_done  = 1'b1;
                rsp_valid  = 1'b1;
                rsp_status = chk_status;
                if (chk_status == STAT_OK) begin
                    rsp_paddr = {chk_ppn, ofs_q};
                end
            end
            default: busy = 1'b0;
        endcase
    end

    // R2: a read request lasts exactly one cycle
    a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R8: an accepted request raises busy on the next cycle
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R9: the response is a single pulse followed by idle
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    // R9: request and response never overlap
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && rsp_valid));

    // R3: a fault never carries an address
    a_r3_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != STAT_OK) |-> (rsp_paddr == '0));

    // R4: a successful store was granted by read/write rights
    a_r4_store_needs_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && kind_q == KIND_STORE && rsp_status == STAT_OK)
            |-> (pte_q[RIGHTS_LSB +: 2] == RIGHT_RW));

    // R5: an invalid entry always reports a page fault
    a_r5_pfault_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !pte_q[PTE_W-1]) |-> (rsp_status == STAT_PFAULT));

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int VA_W  = 40,
    parameter int PA_W  = 36,
    parameter int OFS_W = 14,
    parameter int PTE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kern_mode,
    input  logic             base_wr_en,
    input  logic [PA_W-1:0]  base_wr_data,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             busy,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [PA_W-1:0]  rsp_paddr
);

    localparam int PPN_W = PA_W - OFS_W;

    logic [PA_W-1:0]  base;
    logic [PTE_W-1:0] pte_q;
    logic [1:0]       kind_q;
    logic [1:0]       chk_status;
    logic [PPN_W-1:0] chk_ppn;
    logic             walk_done;

    pw_base_reg #(.PA_W(PA_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .kern_mode (kern_mode),
        .wr_en     (base_wr_en),
        .wr_data   (base_wr_data),
        .walk_busy (busy),
        .walk_done (walk_done),
        .base_q    (base)
    );

    pw_pte_check #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_check (
        .pte    (pte_q),
        .kind   (kind_q),
        .status (chk_status),
        .ppn    (chk_ppn)
    );

    pw_walk_fsm #(
        .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .PTE_W(PTE_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_kind      (req_kind),
        .base          (base),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .chk_status    (chk_status),
        .chk_ppn       (chk_ppn),
        .pte_q         (pte_q),
        .kind_q        (kind_q),
        .busy          (busy),
        .walk_done     (walk_done),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .rsp_valid     (rsp_valid),
        .rsp_status    (rsp_status),
        .rsp_paddr     (rsp_paddr)
    );

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        kern_mode, base_wr_en;
    logic [35:0] base_wr_data;
    logic        req_valid;
    logic [39:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        busy, mem_req, mem_rsp_valid, rsp_valid;
    logic [35:0] mem_addr, rsp_paddr;
    logic [31:0] mem_rsp_data;
    logic [1:0]  rsp_status;

    int total = 0;
    int bad = 0;
    int lat = 1;
    int n_reads = 0;
    logic [31:0] pmem [logic [35:0]];

    always #5 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .kern_mode(kern_mode), .base_wr_en(base_wr_en),
        .base_wr_data(base_wr_data), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr)
    );

    function automatic logic [31:0] mk_pte(input logic v, input logic [1:0] r, input logic [21:0] ppn);
        return {v, 5'b0, r, 2'b0, ppn};
    endfunction

    function automatic logic [35:0] ent_addr(input logic [35:0] b, input logic [25:0] vpn);
        return b + {8'b0, vpn, 2'b00};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic set_pte(input logic [35:0] b, input logic [25:0] vpn, input logic [31:0] pte);
        pmem[ent_addr(b, vpn)] = pte;
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // memory model: answers lat cycles after seeing a read
    initial begin
        logic [35:0] a;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req === 1'b1) begin
                a = mem_addr;
                n_reads++;
                repeat (lat) @(negedge clk);
                mem_rsp_data  = pmem.exists(a) ? pmem[a] : 32'h0;
                mem_rsp_valid = 1'b1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        report();
    end

    task automatic set_base(input logic [35:0] b, input logic kern);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = b; kern_mode = kern;
        @(negedge clk);
        base_wr_en = 1'b0; kern_mode = 1'b0;
    endtask

    task automatic walk(input logic [39:0] va, input logic [1:0] kind,
                        input logic [1:0] exp_st, input logic [35:0] exp_pa,
                        input logic [35:0] exp_ea, input string tag);
        int reads0;
        int k;
        bit got;
        reads0 = n_reads;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R8 busy after accept"}, busy, 1);
        chk({tag, " R2 mem_req"}, mem_req, 1);
        chk({tag, " R2 entry address"}, mem_addr, exp_ea);
        k = 1; got = 0;
        while (k < 40 && !got) begin
            @(negedge clk);
            k++;
            if (rsp_valid) got = 1;
        end
        chk({tag, " R9 response seen"}, got, 1);
        chk({tag, " R9 latency"}, k, 2 + lat);
        chk({tag, " R3/R4 status"}, rsp_status, exp_st);
        chk({tag, " R1 paddr"}, rsp_paddr, exp_pa);
        chk({tag, " R2 one read"}, n_reads, reads0 + 1);
        @(negedge clk);
        chk({tag, " R9 pulse ends"}, rsp_valid, 0);
        chk({tag, " R9 back idle"}, busy, 0);
    endtask

    localparam logic [35:0] B1 = 36'h0_4000_0000;
    localparam logic [35:0] B2 = 36'h8_0000_1000;
    localparam logic [35:0] B3 = 36'h1_2340_0000;
    localparam logic [25:0] VA_ = 26'h012_3456;
    localparam logic [25:0] VB_ = 26'h000_0007;
    localparam logic [25:0] VC_ = 26'h3FF_FFFF;
    localparam logic [25:0] VD_ = 26'h000_0000;
    localparam logic [25:0] VE_ = 26'h0AA_AAAA;
    localparam logic [25:0] VF_ = 26'h001_0001;

    task automatic t_reset();
        chk("R10 busy", busy, 0);
        chk("R10 mem_req", mem_req, 0);
        chk("R10 rsp_valid", rsp_valid, 0);
        walk({VB_, 14'h0010}, 2'b00, 2'b00, {22'h15_5555, 14'h0010},
             ent_addr(36'h0, VB_), "R10 base zero");
    endtask

    task automatic t_rights();
        set_base(B1, 1'b1);
        walk({VA_, 14'h1ABC}, 2'b00, 2'b00, {22'h2A_BCDE, 14'h1ABC}, ent_addr(B1, VA_), "R1 load ro");
        walk({VA_, 14'h0001}, 2'b01, 2'b10, 36'h0, ent_addr(B1, VA_), "R4 store ro");
        walk({VA_, 14'h0002}, 2'b10, 2'b10, 36'h0, ent_addr(B1, VA_), "R4 fetch ro");
        walk({VB_, 14'h2000}, 2'b01, 2'b00, {22'h15_5555, 14'h2000}, ent_addr(B1, VB_), "R4 store rw");
        walk({VB_, 14'h0004}, 2'b10, 2'b10, 36'h0, ent_addr(B1, VB_), "R4 fetch rw");
        walk({VB_, 14'h0004}, 2'b11, 2'b10, 36'h0, ent_addr(B1, VB_), "R4 reserved kind");
        walk({VC_, 14'h3FFF}, 2'b10, 2'b00, 36'hF_FFFF_FFFF, ent_addr(B1, VC_), "R1 fetch exec max");
        walk({VC_, 14'h0000}, 2'b00, 2'b10, 36'h0, ent_addr(B1, VC_), "R4 load exec");
        walk({VD_, 14'h0123}, 2'b00, 2'b10, 36'h0, ent_addr(B1, VD_), "R4 load none");
    endtask

    task automatic t_faults();
        lat = 4;
        walk({VE_, 14'h0007}, 2'b01, 2'b01, 36'h0, ent_addr(B1, VE_), "R5 invalid rw");
        walk({VF_, 14'h0007}, 2'b00, 2'b01, 36'h0, ent_addr(B1, VF_), "R3 invalid empty");
        lat = 1;
    endtask

    task automatic t_base();
        set_base(B2, 1'b0);
        walk({VB_, 14'h0005}, 2'b00, 2'b00, {22'h15_5555, 14'h0005}, ent_addr(B1, VB_), "R6 user write ignored");
        set_base(B2, 1'b1);
        walk({VB_, 14'h0005}, 2'b00, 2'b00, {22'h00_0042, 14'h0005}, ent_addr(B2, VB_), "R6 kernel write");
    endtask

    task automatic t_defer();
        int k;
        bit got;
        int reads0;
        lat = 4;
        reads0 = n_reads;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {VA_, 14'h0100}; req_kind = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        base_wr_en = 1'b1; base_wr_data = B3; kern_mode = 1'b1;
        chk("R7 walk uses old base", mem_addr, ent_addr(B2, VA_));
        @(negedge clk);
        base_wr_en = 1'b0; kern_mode = 1'b0;
        req_valid = 1'b1; req_vaddr = {VB_, 14'h0}; req_kind = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; k = 0;
        while (k < 40 && !got) begin
            @(negedge clk);
            k++;
            if (rsp_valid) got = 1;
        end
        chk("R7 old-base walk status", rsp_status, 2'b00);
        chk("R7 old-base walk paddr", rsp_paddr, {22'h00_0777, 14'h0100});
        repeat (4) @(negedge clk);
        chk("R8 busy request ignored", n_reads, reads0 + 1);
        chk("R8 idle after ignored", busy, 0);
        lat = 1;
        walk({VB_, 14'h0009}, 2'b00, 2'b00, {22'h1F_0F0F, 14'h0009}, ent_addr(B3, VB_), "R7 next walk new base");
    endtask

    initial begin
        rst_n = 1'b0; kern_mode = 1'b0; base_wr_en = 1'b0; base_wr_data = '0;
        req_valid = 1'b0; req_vaddr = '0; req_kind = 2'b00;
        set_pte(36'h0, VB_, mk_pte(1'b1, 2'b10, 22'h15_5555));
        set_pte(B1, VA_, mk_pte(1'b1, 2'b01, 22'h2A_BCDE));
        set_pte(B1, VB_, mk_pte(1'b1, 2'b10, 22'h15_5555));
        set_pte(B1, VC_, mk_pte(1'b1, 2'b11, 22'h3F_FFFF));
        set_pte(B1, VD_, mk_pte(1'b1, 2'b00, 22'h00_0001));
        set_pte(B1, VE_, mk_pte(1'b0, 2'b10, 22'h12_3456));
        set_pte(B2, VB_, mk_pte(1'b1, 2'b10, 22'h00_0042));
        set_pte(B2, VA_, mk_pte(1'b1, 2'b01, 22'h00_0777));
        set_pte(B3, VB_, mk_pte(1'b1, 2'b01, 22'h1F_0F0F));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rights();
        t_faults();
        t_base();
        t_defer();
        repeat (2) @(negedge clk);
        report();
    end

endmodule